// File: doc/BRIEF.md
# Capture-Compare Timer with Delayed One-Shot Output

This block is one timer channel. It has a free-running up-counter that advances by one on each cycle where the prescaler enable is high. An external trigger input is synchronized, and each rising edge on it freezes the counter value into a capture register and pulses a capture interrupt. Two compare registers are checked against the counter. Each match pulses a compare interrupt and can invert the timer output flip-flop. Each compare register has its own toggle-enable bit that gates this inversion.

Together these parts produce a delayed one-shot pulse. On the capture interrupt, software reads the captured value `c`. It loads compare 0 with `c + d` and compare 1 with `c + d + p`, both as 16-bit modular sums, and sets both toggle enables. The output then rises `d` counter steps after the edge and falls `p` steps later. Software clears the enables from the compare interrupt so that no stray toggles follow. A single-cycle register port covers writes and reads: writes take effect at the clock edge, and reads are combinational.

Top module: `cc_oneshot_timer`

## Requirements
- R1: After the active-low asynchronous reset, these are all 0: the counter, capture register, compare registers, toggle enables, `tmr_o`, `irq_cap_o` and `irq_cmp_o`.
- R2: At each clock edge where `tick_i` is 1, the counter (read at address 1) increments by one. Without a tick it holds. After 0xFFFF it wraps to 0x0000.
- R3: A rising edge on `trig_i` copies the counter into the capture register (read at address 0). The copy happens at the third clock edge after the input rises, and it takes the counter value held just before that edge. Holding `trig_i` high captures nothing more.
- R4: `irq_cap_o` is high for exactly the one cycle after the capture edge.
- R5: `irq_cmp_o[k]` pulses for one cycle after a ticked edge where the counter steps onto the value of compare register k (address 4+k). Stalled cycles with an equal counter raise no further pulse.
- R6: On such a step, `tmr_o` inverts when toggle-enable bit k is set. Bit 0 gates compare 0 and bit 1 gates compare 1, in the register at address 2. If both enabled compares match at the same edge, the output inverts once.
- R7: A write of bit 0 to the level register (address 3) sets `tmr_o` at that edge, and it overrides a toggle at the same edge. Reading address 3 returns `tmr_o`.
- R8: A compare register rewritten while the counter runs uses the new value from the next edge on.
- R9: A new capture overwrites the earlier capture value, whether or not that value was read.
- R10: Compare 0 = c+d and compare 1 = c+d+p with both enables set give an output that is high from tick d to tick d+p after the capture. This holds across the counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler enable, one counter step |
| trig_i | input | 1 | External trigger, asynchronous |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_cap_o | output | 1 | Capture interrupt pulse |
| irq_cmp_o | output | 2 | Compare match interrupt pulses, one per compare |
| tmr_o | output | 1 | Timer output flip-flop |

## Verification
The capture result and its interrupt appear three edges after `trig_i` rises. Two of those edges are the synchronizer and one is the capture register. The bench therefore samples the cycle before and the cycle after that edge. A counter step, its compare match, its interrupt and any toggle of `tmr_o` all land at the same edge as the tick, so every tick is followed by a sample at the next falling edge. Register writes show at the following edge and reads are combinational. All inputs are driven on the falling edge, and values are sampled either then or 1 ns later, well clear of the rising edge.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned CMP_BASE = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_CAP  = 3'd0,
    REG_CNT  = 3'd1,
    REG_TGL  = 3'd2,
    REG_LVL  = 3'd3,
    REG_CMP0 = 3'd4,
    REG_CMP1 = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/cct_edge_sync.sv
module cct_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[s] <= 1'b0;
          else         sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] cnt_q;

  assign nxt_o = cnt_q + W'(1);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= nxt_o;
endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] cap_o,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cap_o <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= evt_i;
      if (evt_i) cap_o <= cnt_i;
    end
endmodule

// File: rtl/cct_compare.sv
module cct_compare #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [W-1:0]        nxt_i,
  input  logic [N-1:0][W-1:0] cmp_i,
  input  logic [N-1:0]        tgl_en_i,
  input  logic                lvl_wr_i,
  input  logic                lvl_i,
  output logic [N-1:0]        irq_o,
  output logic                fire_o,
  output logic                tmr_o
);
  logic [N-1:0] hit;

  // match judged on the value the counter steps onto
  generate
    for (genvar k = 0; k < N; k++) begin : g_cmp
      assign hit[k] = tick_i && (nxt_i == cmp_i[k]);
    end
  endgenerate

  assign fire_o = |(hit & tgl_en_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      irq_o <= '0;
      tmr_o <= 1'b0;
    end else begin
      irq_o <= hit;
      if (lvl_wr_i)    tmr_o <= lvl_i;
      else if (fire_o) tmr_o <= ~tmr_o;
    end
endmodule

// File: rtl/cc_oneshot_timer.sv
module cc_oneshot_timer
  import cct_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter int unsigned NUM_CMP     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               trig_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [W-1:0]       wdata_i,
  output logic [W-1:0]       rdata_o,
  output logic               irq_cap_o,
  output logic [NUM_CMP-1:0] irq_cmp_o,
  output logic               tmr_o
);
  logic [W-1:0]              cnt_q;
  logic [W-1:0]              cnt_nxt;
  logic [W-1:0]              cap_q;
  logic                      trig_rise;
  logic [NUM_CMP-1:0][W-1:0] cmp_q;
  logic [NUM_CMP-1:0]        tgl_en_q;
  logic                      lvl_wr;
  logic                      fire;

  cct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(trig_i), .rise_o(trig_rise)
  );

  cct_counter #(.W(W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cnt_o(cnt_q), .nxt_o(cnt_nxt)
  );

  cct_capture #(.W(W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(trig_rise), .cnt_i(cnt_q),
    .cap_o(cap_q), .irq_o(irq_cap_o)
  );

  assign lvl_wr = wr_i && (addr_i == REG_LVL);

  generate
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp_reg
      localparam logic [ADDR_W-1:0] A = ADDR_W'(CMP_BASE + k);
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)                   cmp_q[k] <= '0;
        else if (wr_i && addr_i == A)  cmp_q[k] <= wdata_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                           tgl_en_q <= '0;
    else if (wr_i && addr_i == REG_TGL)    tgl_en_q <= wdata_i[NUM_CMP-1:0];

  cct_compare #(.W(W), .N(NUM_CMP)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .nxt_i(cnt_nxt),
    .cmp_i(cmp_q), .tgl_en_i(tgl_en_q), .lvl_wr_i(lvl_wr), .lvl_i(wdata_i[0]),
    .irq_o(irq_cmp_o), .fire_o(fire), .tmr_o(tmr_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CAP: rdata_o = cap_q;
      REG_CNT: rdata_o = cnt_q;
      REG_TGL: rdata_o = W'(tgl_en_q);
      REG_LVL: rdata_o = W'(tmr_o);
      default: begin
        for (int k = 0; k < NUM_CMP; k++)
          if (addr_i == ADDR_W'(CMP_BASE + k)) rdata_o = cmp_q[k];
      end
    endcase
  end
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk
  import cct_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter int unsigned N = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      cnt_q,
  input logic [W-1:0]      cap_q,
  input logic              irq_cap_o,
  input logic [N-1:0]      irq_cmp_o,
  input logic              fire,
  input logic              tmr_o
);
  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == W'($past(cnt_q) + W'(1)));

  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));

  assert_cap_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_cap_o |-> cap_q == $past(cnt_q));

  assert_cap_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_cap_o |=> !irq_cap_o);

  assert_match_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_cmp_o != '0) |-> $past(tick_i));

  assert_tmr_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tmr_o) |-> ($past(fire) || $past(wr_i && addr_i == REG_LVL)));
endmodule

bind cc_oneshot_timer cct_timer_chk #(.W(W), .N(NUM_CMP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i), .addr_i(addr_i),
  .cnt_q(cnt_q), .cap_q(cap_q), .irq_cap_o(irq_cap_o), .irq_cmp_o(irq_cmp_o),
  .fire(fire), .tmr_o(tmr_o)
);

// File: tb/cc_oneshot_timer_tb.sv
module cc_oneshot_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        trig_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_cap_o;
  logic [1:0]  irq_cmp_o;
  logic        tmr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_CAP = 3'd0, A_CNT = 3'd1, A_TGL = 3'd2, A_LVL = 3'd3,
                         A_CMP0 = 3'd4, A_CMP1 = 3'd5;

  // {delay[15:0], width[15:0], enables[7:0]}
  localparam int NV = 6;
  localparam logic [39:0] VEC [NV] = '{
    {16'd3,  16'd5,  8'd3},
    {16'd1,  16'd1,  8'd3},
    {16'd10, 16'd2,  8'd1},
    {16'd4,  16'd6,  8'd2},
    {16'd6,  16'd3,  8'd0},
    {16'd2,  16'd20, 8'd3}
  };

  always #2 clk_i = ~clk_i;

  cc_oneshot_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .trig_i(trig_i),
    .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_cap_o(irq_cap_o), .irq_cmp_o(irq_cmp_o), .tmr_o(tmr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic capture();
    trig_i = 1'b1;
    repeat (3) @(negedge clk_i);
    @(negedge clk_i);
    trig_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    logic [15:0] v, c, c2;
    int bad, nirq, irq_at;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(A_CNT, v);  chk("R1 cnt", v, 0);
    rd(A_CAP, v);  chk("R1 cap", v, 0);
    rd(A_TGL, v);  chk("R1 tgl", v, 0);
    rd(A_CMP1, v); chk("R1 cmp1", v, 0);
    chk("R1 outputs", {tmr_o, irq_cap_o, irq_cmp_o}, 0);

    // R2 step and hold
    ticks(5);
    rd(A_CNT, v); chk("R2 step", v, 5);
    repeat (4) @(negedge clk_i);
    rd(A_CNT, v); chk("R2 hold", v, 5);

    // R3/R4 capture latency and pulse
    ticks(2);
    trig_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R4 not yet", irq_cap_o, 0);
    @(negedge clk_i);
    chk("R4 pulse", irq_cap_o, 1);
    rd(A_CAP, v); chk("R3 value", v, 7);
    @(negedge clk_i);
    chk("R4 single", irq_cap_o, 0);
    ticks(3);
    rd(A_CAP, v); chk("R3 level no recapture", v, 7);
    trig_i = 1'b0;
    repeat (3) @(negedge clk_i);
    capture();
    rd(A_CAP, v); chk("R9 overwrite", v, 10);

    // R10 / R6 one-shot table
    for (int i = 0; i < NV; i++) begin
      logic [15:0] d, p;
      logic [1:0] en;
      logic exp;
      d = VEC[i][39:24]; p = VEC[i][23:8]; en = VEC[i][1:0];
      capture();
      rd(A_CAP, c);
      wr(A_CMP0, c + d);
      wr(A_CMP1, c + d + p);
      wr(A_TGL, 16'(en));
      wr(A_LVL, 16'd0);
      bad = 0; nirq = 0; irq_at = -1;
      tick_i = 1'b1;
      for (int k = 1; k <= int'(d + p) + 3; k++) begin
        @(negedge clk_i);
        exp = (en[0] && k >= int'(d)) ^ (en[1] && k >= int'(d + p));
        if (tmr_o !== exp) bad++;
        if (irq_cmp_o[0]) begin nirq++; irq_at = k; end
      end
      tick_i = 1'b0;
      chk($sformatf("R10 R6 shape vec%0d", i), bad, 0);
      chk($sformatf("R5 irq vec%0d", i), {nirq[15:0], irq_at[15:0]}, {16'd1, d});
      wr(A_TGL, 16'd0);
    end

    // R5 no repeat while stalled
    rd(A_CNT, c);
    wr(A_CMP0, c + 16'd2); wr(A_CMP1, c + 16'd100);
    wr(A_TGL, 16'd1); wr(A_LVL, 16'd0);
    nirq = 0;
    for (int k = 0; k < 8; k++) begin
      tick_i = (k < 2);
      @(negedge clk_i);
      if (irq_cmp_o[0]) nirq++;
    end
    tick_i = 1'b0;
    chk("R5 stalled once", nirq, 1);
    chk("R6 toggled once", tmr_o, 1);

    // R6 coincident match inverts once
    rd(A_CNT, c);
    wr(A_CMP0, c + 16'd3); wr(A_CMP1, c + 16'd3);
    wr(A_TGL, 16'd3); wr(A_LVL, 16'd0);
    ticks(3);
    chk("R6 coincident", tmr_o, 1);

    // R7 level write beats toggle
    rd(A_CNT, c);
    wr(A_CMP0, c + 16'd1); wr(A_TGL, 16'd1); wr(A_LVL, 16'd0);
    wr_i = 1'b1; addr_i = A_LVL; wdata_i = 16'd0; tick_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; tick_i = 1'b0;
    chk("R7 match seen", irq_cmp_o[0], 1);
    chk("R7 write wins", tmr_o, 0);
    wr(A_LVL, 16'd1);
    rd(A_LVL, v); chk("R7 set level", {tmr_o, v}, {1'b1, 16'd1});

    // R8 compare 1 rewritten mid-pulse
    rd(A_CNT, c);
    wr(A_CMP0, c + 16'd2); wr(A_CMP1, c + 16'd10);
    wr(A_TGL, 16'd3); wr(A_LVL, 16'd0);
    ticks(2);
    wr(A_CMP1, c + 16'd5);
    ticks(2);
    chk("R8 still high", tmr_o, 1);
    ticks(1);
    chk("R8 new value", tmr_o, 0);
    wr(A_TGL, 16'd0);

    // R2 wrap, R10 modular match
    rd(A_CNT, c);
    ticks(int'(16'hFFFE - c));
    rd(A_CNT, v); chk("R2 near wrap", v, 16'hFFFE);
    wr(A_CMP0, 16'd1); wr(A_CMP1, 16'h8000);
    wr(A_TGL, 16'd1); wr(A_LVL, 16'd0);
    ticks(2);
    rd(A_CNT, c2); chk("R2 wrap", {tmr_o, c2}, {1'b0, 16'd0});
    ticks(1);
    chk("R10 across wrap", tmr_o, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule